// File: doc/BRIEF.md
# Three-Lane Time-Slot Serial Transmitter

This block drives three serial data lanes from one shared bit clock enable and one shared slot strobe. Each lane has a 24-bit holding register that software writes through a small register port. When a slot opens, the block copies every enabled holding register into its shift register. The copied word is shaped by the programmed word length, alignment and bit order, and then shifted out one bit per bit-clock enable.

A timing generator outside the block supplies the slot strobe and the frame marker. In network mode a 32-entry slot mask and a one-shot null-slot write decide whether the lanes drive in a given slot. In on-demand mode the block opens a slot by itself as soon as data is written, and it pulses a frame-sync request at that point. Two status outputs report that the holding registers are empty and that a slot opened before fresh data arrived.

Register map (`wr_addr`):
- 0: control word. `[2:0]` word-length code, `[3]` low alignment, `[4]` LSB-first, `[7:5]` lane enables, `[8]` synchronous mode, `[10:9]` mode (0 normal, 1 network, 2 on-demand, 3 network).
- 1: slot mask.
- 2: null slot (the data is ignored).
- 3, 4, 5: holding registers for lanes 0, 1 and 2 (`wr_data[23:0]`).

Top module: `tdm_tx3`

## Requirements
- R1: After reset all output enables are 0, `tde` is 1, `tue` is 0 and `tx0_active` is 0. The slot mask resets to all ones.
- R2: Word-length codes 0/1/2/3 send 8/12/16/24 bits. Code 4 sends 32 bits: the 24 data bits, then data bit 0 repeated eight times. Code 5 sends 32 bits: data bit 23 repeated eight times, then the 24 data bits. Codes 6 and 7 behave as 24 bits. With the alignment bit clear, short words are taken from the top of bits 23..0. With it set, they are taken from the top of bits 15..0. Alignment is ignored for codes 3 to 7.
- R3: With the LSB-first bit clear, the word leaves most significant bit first. With it set, the order is reversed.
- R4: In network mode the slot index is 0 on a strobe with `frame_go` high and otherwise increments. When mask bit n is 0, all output enables stay low in slot n, and neither `tde` nor `tue` is set by that slot.
- R5: A write to the null-slot address clears `tde`. It also keeps every lane quiet in the next slot that opens, even if the mask enables that slot. The null request is consumed by that slot.
- R6: `tde` is set when an enabled slot copies the holding registers. It clears once every enabled lane's holding register has been written, or once the null slot has been written.
- R7: When an enabled slot opens while an enabled lane has no new data, `tue` is set, except in on-demand mode. That lane resends its last holding value.
- R8: Once set, `tue` clears only after a `stat_rd` pulse, followed by a holding-register write that leaves every enabled lane full, or by a null-slot write.
- R9: Lanes 1 and 2 drive only in synchronous mode. `tx0_active` is high while lane 0 drives, but only in synchronous mode with lane 2 disabled.
- R10: In on-demand mode `slot_go` is ignored. A slot opens on the first bit enable after all enabled lanes are full, with `fs_od` high for that cycle. No slot opens while data is missing, and `tue` never sets.
- R11: The first bit and the output enable appear in the clock after the opening strobe. Each later bit follows a bit enable, and the enable falls on the bit enable after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| stat_rd | input | 1 | Status-access pulse that arms the `tue` clear |
| bit_en | input | 1 | One-cycle bit-clock enable |
| slot_go | input | 1 | Slot strobe (qualified by `bit_en`) |
| frame_go | input | 1 | Marks the strobed slot as slot 0 |
| sdo | output | 3 | Serial data, one bit per lane |
| sdo_oe | output | 3 | Output enable, one bit per lane |
| tx0_active | output | 1 | Lane 0 driving indicator |
| fs_od | output | 1 | On-demand frame-sync pulse |
| tde | output | 1 | Holding registers empty |
| tue | output | 1 | Underrun flag |

## Verification
The shaping path is driven with random holding values across all six length codes, both alignments and both bit orders. Directed words with isolated end bits show that 32-bit padding repeats the correct edge bit. Short words with a set alignment bit would expose a wrong source window.

Some slots run with random idle cycles between bit enables, and others run back to back. This shows that bits advance only on bit enables. Network sequences mix masked slots, null slots and empty holding registers, so that each way of suppressing a slot is told apart from the status flags it must leave unchanged. On-demand runs pulse `slot_go` while no data is pending, to prove that the strobe has no effect.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int HOLD_W   = 24;
  localparam int SLOT_MAX = 32;
  localparam int TX_LANES = 3;
  localparam int NB_W     = $clog2(SLOT_MAX + 1);

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_NET    = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_NET_B  = 2'd3
  } tx_mode_e;

  typedef struct packed {
    tx_mode_e            mode;
    logic                sync;
    logic [TX_LANES-1:0] ch_en;
    logic                lsb_first;
    logic                align_lo;
    logic [2:0]          wl;
  } tx_ctrl_t;

  localparam int CTRL_W = $bits(tx_ctrl_t);

  // bits per slot word for a length code
  function automatic logic [NB_W-1:0] word_bits(input logic [2:0] wl);
    case (wl)
      3'd0:       return NB_W'(8);
      3'd1:       return NB_W'(12);
      3'd2:       return NB_W'(16);
      3'd4, 3'd5: return NB_W'(32);
      default:    return NB_W'(24);
    endcase
  endfunction

  // slot word right-justified, most significant transmitted bit at [n-1]
  function automatic logic [SLOT_MAX-1:0] pack_word(input logic [HOLD_W-1:0] h,
                                                    input logic [2:0] wl,
                                                    input logic align_lo);
    logic [SLOT_MAX-1:0] w;
    w = '0;
    case (wl)
      3'd0:    w[7:0]  = align_lo ? h[15:8] : h[23:16];
      3'd1:    w[11:0] = align_lo ? h[15:4] : h[23:12];
      3'd2:    w[15:0] = align_lo ? h[15:0] : h[23:8];
      3'd4:    w = {h, {8{h[0]}}};
      3'd5:    w = {{8{h[23]}}, h};
      default: w[23:0] = h;
    endcase
    return w;
  endfunction

  // place the first bit to send at the top of the shift register
  function automatic logic [SLOT_MAX-1:0] stage_word(input logic [SLOT_MAX-1:0] w,
                                                     input logic [NB_W-1:0] n,
                                                     input logic lsb_first);
    logic [SLOT_MAX-1:0] r;
    if (lsb_first) begin
      for (int i = 0; i < SLOT_MAX; i++) r[i] = w[SLOT_MAX-1-i];
    end else begin
      r = w << (NB_W'(SLOT_MAX) - n);
    end
    return r;
  endfunction
endpackage

// File: rtl/tx_lane.sv
module tx_lane
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hold,
  input  logic [HOLD_W-1:0] wr_val,
  input  logic              load,
  input  logic              lane_en,
  input  logic              shift,
  input  logic [2:0]        wl,
  input  logic              align_lo,
  input  logic              lsb_first,
  input  logic [NB_W-1:0]   nbits,
  output logic              full,
  output logic              sdo,
  output logic              drive
);
  logic [HOLD_W-1:0]   hold_q;
  logic [SLOT_MAX-1:0] sh_q;
  logic                full_q, drive_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      sh_q    <= '0;
      full_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      if (load) begin
        sh_q    <= stage_word(pack_word(hold_q, wl, align_lo), nbits, lsb_first);
        drive_q <= lane_en;
        if (lane_en) full_q <= 1'b0;
      end else if (shift) begin
        sh_q <= sh_q << 1;
      end
      if (wr_hold) begin
        hold_q <= wr_val;
        full_q <= 1'b1;
      end
    end
  end

  assign full  = full_q;
  assign sdo   = sh_q[SLOT_MAX-1];
  assign drive = drive_q;
endmodule

// File: rtl/tx_slot_ctl.sv
module tx_slot_ctl
  import tdm_tx_pkg::*;
#(
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              slot_go,
  input  logic              frame_go,
  input  tx_mode_e          mode,
  input  logic [MASK_W-1:0] mask,
  input  logic              null_wr,
  input  logic [NB_W-1:0]   nbits,
  input  logic              od_ready,
  output logic              slot_start,
  output logic              load,
  output logic              active,
  output logic              shift,
  output logic              fs_od
);
  localparam int IDX_W = $clog2(MASK_W);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [NB_W-1:0]  cnt_q;
  logic             active_q, null_q, fs_q;
  logic             net_mode, ext_start, od_start, mask_ok;

  always_comb begin
    net_mode   = (mode == MODE_NET) || (mode == MODE_NET_B);
    ext_start  = bit_en && slot_go && (mode != MODE_DEMAND);
    od_start   = bit_en && (mode == MODE_DEMAND) && !active_q && od_ready;
    slot_start = ext_start || od_start;
    if (net_mode) idx_d = frame_go ? '0 : idx_q + 1'b1;
    else          idx_d = '0;
    mask_ok    = net_mode ? mask[idx_d] : 1'b1;
    load       = slot_start && mask_ok && (!null_q || od_start);
    shift      = bit_en && active_q && (cnt_q != '0) && !slot_start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      null_q   <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      fs_q <= od_start;
      if (slot_start) begin
        idx_q    <= idx_d;
        null_q   <= 1'b0;
        active_q <= load;
        cnt_q    <= nbits - 1'b1;
      end else if (bit_en && active_q) begin
        if (cnt_q == '0) active_q <= 1'b0;
        else             cnt_q    <= cnt_q - 1'b1;
      end
      if (null_wr) null_q <= 1'b1;
    end
  end

  assign active = active_q;
  assign fs_od  = fs_q;
endmodule

// File: rtl/tx_flags.sv
module tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic any_empty,
  input  logic allow_tue,
  input  logic all_written,
  input  logic hold_wr_evt,
  input  logic null_wr,
  input  logic stat_rd,
  output logic tde,
  output logic tue,
  output logic clr_armed
);
  logic tde_q, tue_q, armed_q, wseen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tde_q   <= 1'b1;
      tue_q   <= 1'b0;
      armed_q <= 1'b0;
      wseen_q <= 1'b0;
    end else begin
      if (load)                          tde_q <= 1'b1;
      else if (all_written || null_wr)   tde_q <= 1'b0;

      if (load && any_empty && allow_tue) begin
        tue_q   <= 1'b1;
        armed_q <= 1'b0;
        wseen_q <= 1'b0;
      end else if (armed_q && (null_wr || (wseen_q && all_written))) begin
        tue_q   <= 1'b0;
        armed_q <= 1'b0;
        wseen_q <= 1'b0;
      end else begin
        if (stat_rd && tue_q)      armed_q <= 1'b1;
        if (armed_q && hold_wr_evt) wseen_q <= 1'b1;
      end
    end
  end

  assign tde       = tde_q;
  assign tue       = tue_q;
  assign clr_armed = armed_q;
endmodule

// File: rtl/tdm_tx3.sv
module tdm_tx3
  import tdm_tx_pkg::*;
#(
  parameter int MASK_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                stat_rd,
  input  logic                bit_en,
  input  logic                slot_go,
  input  logic                frame_go,
  output logic [TX_LANES-1:0] sdo,
  output logic [TX_LANES-1:0] sdo_oe,
  output logic                tx0_active,
  output logic                fs_od,
  output logic                tde,
  output logic                tue
);
  localparam int NCH = TX_LANES;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_NULL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HOLD0 = ADDR_W'(3);

  tx_ctrl_t          ctrl_q;
  logic [MASK_W-1:0] mask_q;
  logic [NCH-1:0]    eff_en, hold_wr, full, drive;
  logic [NB_W-1:0]   nbits;

  // named event wires, used by the logic and by the checker
  logic ctrl_wr, null_wr, hold_wr_evt, all_written, any_empty, od_ready;
  logic slot_start, load, active, shift, clr_armed, sync_mode, mode_demand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= tx_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == A_MASK) mask_q <= wr_data[MASK_W-1:0];
    end
  end

  assign ctrl_wr     = wr_en && (wr_addr == A_CTRL);
  assign null_wr     = wr_en && (wr_addr == A_NULL);
  assign sync_mode   = ctrl_q.sync;
  assign mode_demand = (ctrl_q.mode == MODE_DEMAND);
  assign nbits       = word_bits(ctrl_q.wl);

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    if (i == 0) begin : g_base
      assign eff_en[i] = ctrl_q.ch_en[i];
    end else begin : g_sync_only
      assign eff_en[i] = ctrl_q.ch_en[i] && ctrl_q.sync;
    end
    assign hold_wr[i] = wr_en && (wr_addr == A_HOLD0 + ADDR_W'(i));

    tx_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hold   (hold_wr[i]),
      .wr_val    (wr_data[HOLD_W-1:0]),
      .load      (load),
      .lane_en   (eff_en[i]),
      .shift     (shift),
      .wl        (ctrl_q.wl),
      .align_lo  (ctrl_q.align_lo),
      .lsb_first (ctrl_q.lsb_first),
      .nbits     (nbits),
      .full      (full[i]),
      .sdo       (sdo[i]),
      .drive     (drive[i])
    );
    assign sdo_oe[i] = active && drive[i];
  end

  assign hold_wr_evt = |(hold_wr & eff_en);
  assign all_written = (eff_en != '0) && (&(full | ~eff_en));
  assign any_empty   = |(eff_en & ~full);
  assign od_ready    = all_written;
  assign tx0_active  = ctrl_q.sync && !eff_en[NCH-1] && sdo_oe[0];

  tx_slot_ctl #(.MASK_W(MASK_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .slot_go    (slot_go),
    .frame_go   (frame_go),
    .mode       (ctrl_q.mode),
    .mask       (mask_q),
    .null_wr    (null_wr),
    .nbits      (nbits),
    .od_ready   (od_ready),
    .slot_start (slot_start),
    .load       (load),
    .active     (active),
    .shift      (shift),
    .fs_od      (fs_od)
  );

  tx_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .any_empty   (any_empty),
    .allow_tue   (!mode_demand),
    .all_written (all_written),
    .hold_wr_evt (hold_wr_evt),
    .null_wr     (null_wr),
    .stat_rd     (stat_rd),
    .tde         (tde),
    .tue         (tue),
    .clr_armed   (clr_armed)
  );
endmodule

// File: rtl/tdm_tx3_chk.sv
module tdm_tx3_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_en,
  input logic           sync_mode,
  input logic           mode_demand,
  input logic           ctrl_wr,
  input logic           slot_start,
  input logic           load,
  input logic           any_empty,
  input logic           clr_armed,
  input logic           tde,
  input logic           tue,
  input logic           tx0_active,
  input logic [NCH-1:0] sdo_oe
);
  p_sync_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> ((sdo_oe >> 1) == '0));

  p_tx0_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx0_active |-> sdo_oe[0]);

  p_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !load) |=> (sdo_oe == '0));

  p_tde_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tde);

  p_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && any_empty && !mode_demand) |=> tue);

  p_tue_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tue) |-> $past(clr_armed));

  p_demand_no_tue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_demand && !ctrl_wr && !tue) |=> !tue);

  p_oe_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|sdo_oe) |-> $past(bit_en));
endmodule

bind tdm_tx3 tdm_tx3_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .sync_mode   (sync_mode),
  .mode_demand (mode_demand),
  .ctrl_wr     (ctrl_wr),
  .slot_start  (slot_start),
  .load        (load),
  .any_empty   (any_empty),
  .clr_armed   (clr_armed),
  .tde         (tde),
  .tue         (tue),
  .tx0_active  (tx0_active),
  .sdo_oe      (sdo_oe)
);

// File: tb/tdm_tx3_bench.sv
module tdm_tx3_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        stat_rd = 1'b0;
  logic        bit_en = 1'b0;
  logic        slot_go = 1'b0;
  logic        frame_go = 1'b0;
  logic [2:0]  sdo, sdo_oe;
  logic        tx0_active, fs_od, tde, tue;

  int n_chk = 0;
  int n_fail = 0;
  logic cap_sdo [3][40];
  logic cap_oe  [3][40];
  logic cap_act [40];

  always #2 clk = ~clk;

  tdm_tx3 u_tdm_tx3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .bit_en(bit_en), .slot_go(slot_go), .frame_go(frame_go),
    .sdo(sdo), .sdo_oe(sdo_oe), .tx0_active(tx0_active), .fs_od(fs_od),
    .tde(tde), .tue(tue)
  );

  function automatic int wbits(int wl);
    if (wl == 0) return 8;
    if (wl == 1) return 12;
    if (wl == 2) return 16;
    if (wl == 4 || wl == 5) return 32;
    return 24;
  endfunction

  // expected k-th transmitted bit
  function automatic logic exp_bit(logic [23:0] h, int wl, bit al, bit lsb, int k);
    int n, j, top;
    n = wbits(wl);
    j = lsb ? (n - 1 - k) : k;
    if (wl == 4) return (j < 24) ? h[23-j] : h[0];
    if (wl == 5) return (j < 8) ? h[23] : h[31-j];
    if (n == 24) return h[23-j];
    top = al ? 15 : 23;
    return h[top-j];
  endfunction

  function automatic logic [31:0] mk_ctrl(int mode, bit sync, int en, bit lsb, bit al, int wl);
    return (32'(mode) << 9) | (32'(sync) << 8) | (32'(en) << 5) |
           (32'(lsb) << 4) | (32'(al) << 3) | 32'(wl);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int c);
    for (int i = 0; i < c; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic run_slot(bit frame, int len, bit gaps);
    for (int k = 0; k < len; k++) begin
      if (gaps) begin
        bit_en = 1'b0; slot_go = 1'b0; frame_go = 1'b0;
        idle($urandom % 3);
      end
      bit_en = 1'b1; slot_go = (k == 0); frame_go = frame && (k == 0);
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        cap_sdo[c][k] = sdo[c];
        cap_oe[c][k]  = sdo_oe[c];
      end
      cap_act[k] = tx0_active;
      slot_go = 1'b0; frame_go = 1'b0;
    end
    bit_en = 1'b0;
  endtask

  task automatic chk_lane(int ch, logic [23:0] h, int wl, bit al, bit lsb, int len, string req);
    int n, bad;
    logic ab, eb;
    n = wbits(wl); bad = -1; ab = 0; eb = 0;
    for (int k = 0; k < len; k++) begin
      if (bad < 0) begin
        if (cap_oe[ch][k] !== (k < n)) begin
          bad = k; ab = cap_oe[ch][k]; eb = (k < n);
        end else if (k < n && cap_sdo[ch][k] !== exp_bit(h, wl, al, lsb, k)) begin
          bad = k; ab = cap_sdo[ch][k]; eb = exp_bit(h, wl, al, lsb, k);
        end
      end
    end
    if (bad >= 0)
      $display("  lane %0d wl %0d align %0d lsb %0d data %h: first mismatch at bit %0d",
               ch, wl, al, lsb, h, bad);
    check(bad < 0, req, "lane bit/oe", longint'(ab), longint'(eb));
  endtask

  task automatic chk_quiet(int ch, int len, string req);
    int hits;
    hits = 0;
    for (int k = 0; k < len; k++) if (cap_oe[ch][k] !== 1'b0) hits++;
    check(hits == 0, req, "enable during quiet slot", hits, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] h [3];
    int wl;
    bit al, lsb;
    void'($urandom(32'h1D5E_ED01));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(sdo_oe == 3'b000, "R1", "sdo_oe", sdo_oe, 0);
    check(tde == 1'b1, "R1", "tde", tde, 1);
    check(tue == 1'b0, "R1", "tue", tue, 0);
    check(tx0_active == 1'b0, "R1", "tx0_active", tx0_active, 0);

    // R2 R3 R11: random shaping, all lanes in synchronous normal mode
    for (int it = 0; it < 14; it++) begin
      wl = $urandom % 6;
      al = (wl < 3) ? bit'($urandom % 2) : 1'b0;
      lsb = bit'($urandom % 2);
      for (int c = 0; c < 3; c++) h[c] = 24'($urandom);
      if (it == 0) begin wl = 4; lsb = 0; h[0] = 24'h000001; end
      if (it == 1) begin wl = 5; lsb = 0; h[0] = 24'h800000; end
      if (it == 2) begin wl = 0; al = 1; lsb = 1; end
      wr(0, mk_ctrl(0, 1, 7, lsb, al, wl));
      wr(3, {8'h0, h[0]});
      wr(4, {8'h0, h[1]});
      idle(1);
      if (it == 0) check(tde == 1'b1, "R6", "tde with lane 2 unwritten", tde, 1);
      wr(5, {8'h0, h[2]});
      idle(1);
      check(tde == 1'b0, "R6", "tde after all lanes written", tde, 0);
      run_slot(1'b0, wbits(wl) + 2, bit'(it % 2));
      for (int c = 0; c < 3; c++) chk_lane(c, h[c], wl, al, lsb, wbits(wl) + 2, "R2 R3 R11");
      check(tde == 1'b1, "R6", "tde after transfer", tde, 1);
      check(tue == 1'b0, "R7", "tue with full lanes", tue, 0);
    end

    // R9: asynchronous mode gates lanes 1 and 2
    wr(0, mk_ctrl(0, 0, 7, 0, 0, 0));
    h[0] = 24'hA5C3F0;
    wr(3, {8'h0, h[0]}); wr(4, 32'h00FFFFFF); wr(5, 32'h00FFFFFF);
    run_slot(1'b0, 10, 1'b0);
    chk_lane(0, h[0], 0, 0, 0, 10, "R9");
    chk_quiet(1, 10, "R9");
    chk_quiet(2, 10, "R9");
    check(cap_act[0] == 1'b0, "R9", "tx0_active async", cap_act[0], 0);
    wr(0, mk_ctrl(0, 1, 3, 0, 0, 0));
    wr(3, {8'h0, h[0]}); wr(4, 32'h0012_3456);
    run_slot(1'b0, 10, 1'b0);
    check(cap_act[0] == 1'b1, "R9", "tx0_active while driving", cap_act[0], 1);
    check(cap_act[9] == 1'b0, "R9", "tx0_active after word", cap_act[9], 0);
    chk_quiet(2, 10, "R9");

    // R4: network mode with slots 0 and 3 enabled
    wr(0, mk_ctrl(1, 1, 1, 0, 0, 2));
    wr(1, 32'h0000_0009);
    wr(3, 32'h00_1234AB);
    run_slot(1'b1, 18, 1'b0);
    chk_lane(0, 24'h1234AB, 2, 0, 0, 18, "R4");
    wr(3, 32'h00_C0FFEE);
    idle(1);
    check(tde == 1'b0, "R6", "tde after rewrite", tde, 0);
    run_slot(1'b0, 18, 1'b0);
    chk_quiet(0, 18, "R4");
    check(tde == 1'b0, "R4", "tde in masked slot", tde, 0);
    run_slot(1'b0, 18, 1'b1);
    chk_quiet(0, 18, "R4");
    run_slot(1'b0, 18, 1'b0);
    chk_lane(0, 24'hC0FFEE, 2, 0, 0, 18, "R4");
    run_slot(1'b0, 18, 1'b0);
    chk_quiet(0, 18, "R4");
    check(tue == 1'b0, "R4", "tue in masked empty slot", tue, 0);

    // R5: null slot overrides an enabled mask bit
    wr(1, 32'hFFFF_FFFF);
    check(tde == 1'b1, "R6", "tde before null", tde, 1);
    wr(2, 32'h0);
    idle(1);
    check(tde == 1'b0, "R5", "tde after null write", tde, 0);
    run_slot(1'b0, 18, 1'b0);
    chk_quiet(0, 18, "R5");
    check(tue == 1'b0, "R5", "tue in null slot", tue, 0);
    wr(3, 32'h00_0F0F0F);
    run_slot(1'b0, 18, 1'b0);
    chk_lane(0, 24'h0F0F0F, 2, 0, 0, 18, "R5");

    // R7 R8: underrun and its clear sequence
    wr(0, mk_ctrl(0, 0, 1, 0, 0, 3));
    wr(3, 32'h00_9A6B3C);
    run_slot(1'b0, 26, 1'b0);
    chk_lane(0, 24'h9A6B3C, 3, 0, 0, 26, "R7");
    check(tue == 1'b0, "R7", "tue after fed slot", tue, 0);
    run_slot(1'b0, 26, 1'b0);
    chk_lane(0, 24'h9A6B3C, 3, 0, 0, 26, "R7");
    check(tue == 1'b1, "R7", "tue after starved slot", tue, 1);
    wr(3, 32'h00_111111);
    idle(3);
    check(tue == 1'b1, "R8", "tue after write without read", tue, 1);
    pulse_rd();
    idle(3);
    check(tue == 1'b1, "R8", "tue after read without write", tue, 1);
    wr(3, 32'h00_5EA5EA);
    idle(3);
    check(tue == 1'b0, "R8", "tue after read then write", tue, 0);
    run_slot(1'b0, 26, 1'b0);
    chk_lane(0, 24'h5EA5EA, 3, 0, 0, 26, "R7");

    // R10: on-demand mode
    begin
      int found, hits;
      wr(0, mk_ctrl(2, 0, 1, 1, 0, 0));
      bit_en = 1'b1;
      wr(3, 32'h00_3C0000);
      found = 0;
      for (int t = 0; t < 6 && found == 0; t++) begin
        @(posedge clk);
        @(negedge clk);
        if (fs_od) found = 1;
      end
      check(found == 1, "R10", "fs_od after write", found, 1);
      cap_sdo[0][0] = sdo[0]; cap_oe[0][0] = sdo_oe[0];
      for (int k = 1; k < 10; k++) begin
        @(posedge clk);
        @(negedge clk);
        cap_sdo[0][k] = sdo[0]; cap_oe[0][k] = sdo_oe[0];
      end
      chk_lane(0, 24'h3C0000, 0, 0, 1, 10, "R10");
      hits = 0;
      for (int t = 0; t < 40; t++) begin
        slot_go = (t % 9 == 0);
        @(posedge clk);
        @(negedge clk);
        if (sdo_oe != 3'b000 || fs_od) hits++;
      end
      slot_go = 1'b0; bit_en = 1'b0;
      check(hits == 0, "R10", "activity with no data", hits, 0);
      check(tue == 1'b0, "R10", "tue in on-demand", tue, 0);
    end

    summary();
    $finish;
  end
endmodule